// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash. It watches bus write cycles (address, data and a one-cycle write strobe, all sampled on the rising clock edge) and recognises a three-write sequence. The first two writes are the usual unlock pair. The third write carries a configuration command in its data byte and an 8-bit configuration code in the upper address bits. When the sequence completes, the code is latched into the burst configuration register. One bit of that code turns synchronous (burst) mode on.

A `busy` input shows that a program, erase or lock operation is running elsewhere in the device. A configuration load that completes while `busy` is high is discarded. Any write that does not fit the expected next step puts the decoder into a sticky error state. In that state every further write is ignored until the reset command arrives. The reset command is a single write of F0h. It clears the error and any partly entered sequence, and it leaves the configuration register as it is. A hardware reset restores the default configuration, which selects asynchronous mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and after it rises, `cfg_code` is 00h, `sync_en` is 0 and `seq_err` is 0. A partly entered sequence is discarded, so a lone C0h write at low address 555h that follows reset is an error.
- R2: Three writes load `addr[19:12]` of the third write into `cfg_code`. The writes are data AAh at low address 555h, then data 55h at low address 2AAh, then data C0h at low address 555h. The new value is visible in the cycle after the third write.
- R3: Only `addr[11:0]` and `data[7:0]` are compared. Set bits in `addr[19:12]` during the unlock writes, or in `data[15:8]`, do not break a sequence.
- R4: `sync_en` equals bit 7 of `cfg_code`, where 1 means synchronous mode.
- R5: A configuration load whose third write arrives with `busy` high leaves `cfg_code` unchanged and raises no error. The decoder returns to idle, so a later sequence with `busy` low loads. A `busy` level during the unlock writes has no effect.
- R6: A write with the wrong data or low address at any step, or a write out of order, sets `seq_err` in the next cycle. While `seq_err` is set, every write other than the reset command leaves `seq_err` and `cfg_code` unchanged.
- R7: A write whose `data[7:0]` is F0h, at any address and with any `busy` level, clears `seq_err` in the next cycle and leaves `cfg_code` unchanged.
- R8: After a complete sequence the decoder is idle, so a second sequence may follow with no gap.
- R9: Cycles with `wr_en` low change neither output nor the sequence position.
- R10: A reset command in the middle of a sequence discards it, so a following 55h write at 2AAh is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe; high for one cycle per bus write |
| busy | input | 1 | High while an embedded program, erase or lock runs |
| addr | input | 20 | Write address; bits 11:0 are compared, bits 19:12 are the code |
| data | input | 16 | Write data; bits 7:0 hold the command byte |
| cfg_code | output | 8 | Latched configuration code |
| sync_en | output | 1 | Synchronous burst mode enabled |
| seq_err | output | 1 | Sticky sequence error |

## Verification
The two functions that can fall in the same cycle are the configuration load and the busy interlock. The third write of a valid sequence is driven in the same cycle that `busy` is high. The bench then checks, in the next cycle, that `cfg_code` still holds its previous value and `seq_err` is still clear. A sequence with `busy` low follows at once, and its load proves the decoder went back to idle rather than stalling. A reset command issued with `busy` high checks that the interlock does not hold back error recovery.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    // Command bytes, compared against data[7:0]
    localparam logic [7:0] UNLOCK_A_BYTE = 8'hAA;
    localparam logic [7:0] UNLOCK_B_BYTE = 8'h55;
    localparam logic [7:0] CFG_BYTE      = 8'hC0;
    localparam logic [7:0] RESET_BYTE    = 8'hF0;

    // Sequence position of the decoder
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UNL1 = 2'd1,
        ST_UNL2 = 2'd2,
        ST_ERR  = 2'd3
    } seq_state_e;

    // Classification of one bus write
    typedef enum logic [2:0] {
        CMD_OTHER    = 3'd0,
        CMD_UNLOCK_A = 3'd1,
        CMD_UNLOCK_B = 3'd2,
        CMD_CFG      = 3'd3,
        CMD_RESET    = 3'd4
    } cmd_kind_e;

endpackage

// File: rtl/flcmd_classify.sv
module flcmd_classify
    import flcmd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int LOW_ADDR_W = 12,
    parameter logic [LOW_ADDR_W-1:0] ADDR_A = 12'h555,
    parameter logic [LOW_ADDR_W-1:0] ADDR_B = 12'h2AA,
    localparam int CODE_W = ADDR_W - LOW_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output cmd_kind_e         kind,
    output logic [CODE_W-1:0] payload
);

    logic [7:0]            cmd_byte;
    logic [LOW_ADDR_W-1:0] low_addr;
    logic                  hit_a;
    logic                  hit_b;
    logic                  unused_data_hi;

    assign cmd_byte = data[7:0];
    assign low_addr = addr[LOW_ADDR_W-1:0];
    assign payload  = addr[ADDR_W-1:LOW_ADDR_W];

    // The upper data byte carries no command meaning
    generate
        if (DATA_W > 8) begin : g_wide_data
            assign unused_data_hi = ^data[DATA_W-1:8];
        end else begin : g_narrow_data
            assign unused_data_hi = 1'b0;
        end
    endgenerate

    assign hit_a = (low_addr == ADDR_A);
    assign hit_b = (low_addr == ADDR_B);

    // The reset byte wins at any address
    always_comb begin
        kind = CMD_OTHER;
        if (cmd_byte == RESET_BYTE) begin
            kind = CMD_RESET;
        end else if (cmd_byte == UNLOCK_A_BYTE && hit_a) begin
            kind = CMD_UNLOCK_A;
        end else if (cmd_byte == UNLOCK_B_BYTE && hit_b) begin
            kind = CMD_UNLOCK_B;
        end else if (cmd_byte == CFG_BYTE && hit_a) begin
            kind = CMD_CFG;
        end
    end

endmodule

// File: rtl/flcmd_seq_fsm.sv
module flcmd_seq_fsm
    import flcmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      busy,
    input  cmd_kind_e kind,
    output logic      load_en,
    output logic      seq_err
);

    typedef struct packed {
        seq_state_e state;
    } fsm_t;

    fsm_t fsm_d;
    fsm_t fsm_q;

    always_comb begin
        fsm_d   = fsm_q;
        load_en = 1'b0;
        if (wr_en) begin
            unique case (fsm_q.state)
                ST_IDLE: begin
                    if (kind == CMD_UNLOCK_A)   fsm_d.state = ST_UNL1;
                    else if (kind == CMD_RESET) fsm_d.state = ST_IDLE;
                    else                        fsm_d.state = ST_ERR;
                end
                ST_UNL1: begin
                    if (kind == CMD_UNLOCK_B)   fsm_d.state = ST_UNL2;
                    else if (kind == CMD_RESET) fsm_d.state = ST_IDLE;
                    else                        fsm_d.state = ST_ERR;
                end
                ST_UNL2: begin
                    if (kind == CMD_CFG) begin
                        // The sequence always completes; busy only drops the load
                        fsm_d.state = ST_IDLE;
                        load_en     = ~busy;
                    end else if (kind == CMD_RESET) begin
                        fsm_d.state = ST_IDLE;
                    end else begin
                        fsm_d.state = ST_ERR;
                    end
                end
                ST_ERR: begin
                    if (kind == CMD_RESET) fsm_d.state = ST_IDLE;
                end
                default: fsm_d.state = ST_ERR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_IDLE};
        else        fsm_q <= fsm_d;
    end

    assign seq_err = (fsm_q.state == ST_ERR);

endmodule

// File: rtl/flcmd_cfg_reg.sv
module flcmd_cfg_reg #(
    parameter int                CODE_W      = 8,
    parameter logic [CODE_W-1:0] CFG_DEFAULT = '0,
    parameter int                SYNC_BIT    = 7,
    parameter bit                SYNC_POL    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code,
    output logic              sync_en
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } cfg_t;

    cfg_t cfg_d;
    cfg_t cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_en) cfg_d.code = code_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{code: CFG_DEFAULT};
        else        cfg_q <= cfg_d;
    end

    assign code = cfg_q.code;

    // The polarity of the mode bit is chosen at build time
    generate
        if (SYNC_POL) begin : g_sync_high
            assign sync_en = cfg_q.code[SYNC_BIT];
        end else begin : g_sync_low
            assign sync_en = ~cfg_q.code[SYNC_BIT];
        end
    endgenerate

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flcmd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int LOW_ADDR_W = 12,
    parameter logic [LOW_ADDR_W-1:0] ADDR_A = 12'h555,
    parameter logic [LOW_ADDR_W-1:0] ADDR_B = 12'h2AA,
    parameter int SYNC_BIT   = 7,
    parameter bit SYNC_POL   = 1'b1,
    localparam int CODE_W    = ADDR_W - LOW_ADDR_W,
    parameter logic [CODE_W-1:0] CFG_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] cfg_code,
    output logic              sync_en,
    output logic              seq_err
);

    cmd_kind_e         kind;
    logic [CODE_W-1:0] payload;
    logic              load_en;

    flcmd_classify #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LOW_ADDR_W (LOW_ADDR_W),
        .ADDR_A     (ADDR_A),
        .ADDR_B     (ADDR_B)
    ) u_classify (
        .addr    (addr),
        .data    (data),
        .kind    (kind),
        .payload (payload)
    );

    flcmd_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .busy    (busy),
        .kind    (kind),
        .load_en (load_en),
        .seq_err (seq_err)
    );

    flcmd_cfg_reg #(
        .CODE_W      (CODE_W),
        .CFG_DEFAULT (CFG_DEFAULT),
        .SYNC_BIT    (SYNC_BIT),
        .SYNC_POL    (SYNC_POL)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .code_in (payload),
        .code    (cfg_code),
        .sync_en (sync_en)
    );

endmodule

// File: rtl/flcmd_checker.sv
module flcmd_checker #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] CFG_DEFAULT = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data,
    input logic [CODE_W-1:0] cfg_code,
    input logic              sync_en,
    input logic              seq_err
);

    logic unused_bus_bits;
    assign unused_bus_bits = ^{addr[ADDR_W-1:12], data[DATA_W-1:8]};

    // R1: reset forces the default configuration and clears the error
    assert_default_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_code == CFG_DEFAULT && !seq_err));

    // R2: the register only changes after a C0h write at low address 555h
    assert_load_needs_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_code) |-> ($past(wr_en) && $past(data[7:0]) == 8'hC0
                                && $past(addr[11:0]) == 12'h555));

    // R4: the mode flag moves only after a write
    assert_sync_moves_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_en) |-> $past(wr_en));

    // R5: a write while busy never alters the register
    assert_busy_blocks_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> $stable(cfg_code));

    // R6: the error holds against any write but the reset command
    assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && wr_en && data[7:0] != 8'hF0) |=> seq_err);

    // R7: the reset command clears the error and keeps the register
    assert_reset_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && data[7:0] == 8'hF0) |=> (!seq_err && $stable(cfg_code)));

    // R9: idle bus cycles change nothing visible
    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cfg_code) && $stable(seq_err)));

endmodule

bind flash_cmd_decoder flcmd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .busy     (busy),
    .addr     (addr),
    .data     (data),
    .cfg_code (cfg_code),
    .sync_en  (sync_en),
    .seq_err  (seq_err)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int HALF_NS  = 10;          // 50 MHz clock
    localparam int WDOG_CYC = 5000;
    localparam int NVEC     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        busy = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] data = '0;
    logic [7:0]  cfg_code;
    logic        sync_en;
    logic        seq_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(HALF_NS) clk = ~clk;

    flash_cmd_decoder uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy),
        .addr     (addr),
        .data     (data),
        .cfg_code (cfg_code),
        .sync_en  (sync_en),
        .seq_err  (seq_err)
    );

    // {req, wr, addr, data, busy, expected code, expected error}
    localparam logic [50:0] VEC [NVEC] = '{
        {4'd2,  1'b1, 20'h00555, 16'h00AA, 1'b0, 8'h00, 1'b0}, // R2 unlock 1
        {4'd2,  1'b1, 20'h002AA, 16'h0055, 1'b0, 8'h00, 1'b0}, // R2 unlock 2
        {4'd2,  1'b1, 20'hA5555, 16'h00C0, 1'b0, 8'hA5, 1'b0}, // R2 load A5h
        {4'd9,  1'b0, 20'h12555, 16'h00C0, 1'b0, 8'hA5, 1'b0}, // R9 no strobe
        {4'd3,  1'b1, 20'hFF555, 16'hFFAA, 1'b0, 8'hA5, 1'b0}, // R3 upper bits set
        {4'd3,  1'b1, 20'h3C2AA, 16'hAB55, 1'b0, 8'hA5, 1'b0}, // R3
        {4'd9,  1'b0, 20'h002AA, 16'h00AA, 1'b0, 8'hA5, 1'b0}, // R9 gap mid-sequence
        {4'd3,  1'b1, 20'h3C555, 16'h00C0, 1'b0, 8'h3C, 1'b0}, // R3 load 3Ch
        {4'd8,  1'b1, 20'h00555, 16'h00AA, 1'b0, 8'h3C, 1'b0}, // R8 back to back
        {4'd8,  1'b1, 20'h002AA, 16'h0055, 1'b0, 8'h3C, 1'b0}, // R8
        {4'd8,  1'b1, 20'h81555, 16'h00C0, 1'b0, 8'h81, 1'b0}, // R8 load 81h
        {4'd5,  1'b1, 20'h00555, 16'h00AA, 1'b1, 8'h81, 1'b0}, // R5
        {4'd5,  1'b1, 20'h002AA, 16'h0055, 1'b1, 8'h81, 1'b0}, // R5
        {4'd5,  1'b1, 20'h7E555, 16'h00C0, 1'b1, 8'h81, 1'b0}, // R5 load while busy
        {4'd5,  1'b1, 20'h00555, 16'h00AA, 1'b1, 8'h81, 1'b0}, // R5 busy on unlock
        {4'd5,  1'b1, 20'h002AA, 16'h0055, 1'b1, 8'h81, 1'b0}, // R5
        {4'd5,  1'b1, 20'h42555, 16'h00C0, 1'b0, 8'h42, 1'b0}, // R5 load 42h
        {4'd6,  1'b1, 20'h00555, 16'h00AB, 1'b0, 8'h42, 1'b1}, // R6 bad data
        {4'd6,  1'b1, 20'h00555, 16'h00AA, 1'b0, 8'h42, 1'b1}, // R6 ignored
        {4'd6,  1'b1, 20'h002AA, 16'h0055, 1'b0, 8'h42, 1'b1}, // R6 ignored
        {4'd6,  1'b1, 20'h99555, 16'h00C0, 1'b0, 8'h42, 1'b1}, // R6 no load
        {4'd7,  1'b1, 20'h12345, 16'h00F0, 1'b0, 8'h42, 1'b0}, // R7 recover
        {4'd10, 1'b1, 20'h00555, 16'h00AA, 1'b0, 8'h42, 1'b0}, // R10
        {4'd10, 1'b1, 20'h00000, 16'h00F0, 1'b0, 8'h42, 1'b0}, // R10 abort
        {4'd10, 1'b1, 20'h002AA, 16'h0055, 1'b0, 8'h42, 1'b1}, // R10 now an error
        {4'd7,  1'b1, 20'hABCDE, 16'h00F0, 1'b1, 8'h42, 1'b0}, // R7 while busy
        {4'd6,  1'b1, 20'h002AA, 16'h0055, 1'b0, 8'h42, 1'b1}, // R6 wrong order
        {4'd7,  1'b1, 20'h00000, 16'h00F0, 1'b0, 8'h42, 1'b0}, // R7
        {4'd6,  1'b1, 20'h00555, 16'h00AA, 1'b0, 8'h42, 1'b0}, // R6
        {4'd6,  1'b1, 20'h002AA, 16'h0055, 1'b0, 8'h42, 1'b0}, // R6
        {4'd6,  1'b1, 20'h0F556, 16'h00C0, 1'b0, 8'h42, 1'b1}, // R6 bad third address
        {4'd7,  1'b1, 20'h00000, 16'h00F0, 1'b0, 8'h42, 1'b0}  // R7
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [7:0] code, input logic err);
        check(req, "cfg_code", cfg_code, code);
        check(req, "seq_err", {7'd0, seq_err}, {7'd0, err});
        check("R4", "sync_en", {7'd0, sync_en}, {7'd0, code[7]});
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic bus_write(input logic wr, input logic [19:0] a,
                             input logic [15:0] d, input logic b);
        wr_en = wr;
        addr  = a;
        data  = d;
        busy  = b;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        busy  = 1'b0;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1", 8'h00, 1'b0);           // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 8'h00, 1'b0);           // R1 after release

        for (int i = 0; i < NVEC; i++) begin
            logic [50:0] v;
            string       tag;
            v = VEC[i];
            bus_write(v[46], v[45:26], v[25:10], v[9]);
            tag = $sformatf("R%0d", v[50:47]);
            check_all(tag, v[8:1], v[0]);
        end

        // R1: hardware reset in mid-sequence restores the default
        bus_write(1'b1, 20'h00555, 16'h00AA, 1'b0);
        bus_write(1'b1, 20'h002AA, 16'h0055, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1", 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 8'h00, 1'b0);
        // R1: the unlock progress was lost, so a lone load write is an error
        bus_write(1'b1, 20'h5A555, 16'h00C0, 1'b0);
        check_all("R1", 8'h00, 1'b1);
        bus_write(1'b1, 20'h00000, 16'h00F0, 1'b0);
        check_all("R7", 8'h00, 1'b0);

        // R2: a full load after the hardware reset, with idle cycles between writes
        bus_write(1'b1, 20'h00555, 16'h00AA, 1'b0);
        bus_write(1'b0, 20'h00000, 16'h0000, 1'b0);
        bus_write(1'b1, 20'h002AA, 16'h0055, 1'b0);
        bus_write(1'b0, 20'h00000, 16'h0000, 1'b0);
        bus_write(1'b1, 20'hC3555, 16'h00C0, 1'b0);
        check_all("R2", 8'hC3, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule